// File: doc/BRIEF.md
# Debug Control and Status Register

This block is the debug control and status word of a 32-bit processor core, read and written as a single memory-mapped register. When the core enters debug mode, the block records three conditions: whether the exception hit a branch delay slot, whether the core was in a low-power state, and whether the bus clock was running. It also tracks whether the core is currently in debug mode.

Two writable control bits drive outputs directly. One lets the count timer keep running while in debug mode. The other sends loads and stores in the debug segment range to main memory instead of to the debug segment.

Two sticky pending bits collect bus errors, one for instruction fetches and one for imprecise data accesses. Each is set by a hardware event or by software writing a one. Each clears only when the matching exception is taken, or on reset. While a pending bit is set and the imprecise-exception inhibit input is low, the block asserts the matching exception request.

Top module: `dbg_ctl_reg`

## Requirements
- R1: After reset the read word shows bit 30 = 0, bit 28 = 0, bit 25 = 1, bit 24 = 0 and bit 21 = 0. In the same state `dseg_to_mem` = 0, `timer_run_dbg` = 1, and both exception requests are 0.
- R2: Bit 30 reads 1 from the cycle after an `dx_entry` strobe. It reads 0 from the cycle after a `dx_exit` strobe. When both strobes arrive in the same cycle, entry wins. Software writes do not change bit 30.
- R3: Bits 29, 23 and 22 always read 0, whatever is written. All bits not named in R2 and R4 to R8 (bits 20 down to 0) also read 0.
- R4: Bit 28 is read/write and its value drives `dseg_to_mem` (1 = debug-segment accesses go to main memory). A write takes effect in the cycle after `sw_wr_en`.
- R5: Bit 25 is read/write and its value drives `timer_run_dbg` (1 = timer counts in debug mode, 0 = timer stopped in debug mode). A write takes effect in the cycle after `sw_wr_en`.
- R6: On a `dx_entry` cycle the block captures three inputs: bit 31 takes `dx_in_dslot`, bit 27 takes `dx_lowpwr` and bit 26 takes `dx_clk_run`. These bits hold in every other cycle and ignore software writes. Their value before the first entry after reset is not defined.
- R7: Bit 24 (fetch bus error) is set in the cycle after `ibus_err_evt` or after a software write with data bit 24 = 1. Bit 21 (data bus error) is set the same way by `dbus_err_evt` or a write with data bit 21 = 1. Writing 0 to either bit leaves it unchanged.
- R8: A pending bit clears in the cycle after its taken acknowledge (`ibus_taken` for bit 24, `dbus_taken` for bit 21). If a set (an event or a write of 1) arrives in the same cycle as the acknowledge, the bit is set.
- R9: `ibus_exc_req` equals bit 24 AND NOT `exc_inhibit`, and `dbus_exc_req` equals bit 21 AND NOT `exc_inhibit`. Both requests follow `exc_inhibit` combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Register read value |
| dx_entry | input | 1 | Debug exception entry strobe |
| dx_exit | input | 1 | Debug mode return strobe |
| dx_in_dslot | input | 1 | Exception was in a branch delay slot |
| dx_lowpwr | input | 1 | Core was in a low-power state |
| dx_clk_run | input | 1 | Bus clock was running |
| ibus_err_evt | input | 1 | Instruction fetch bus error event |
| dbus_err_evt | input | 1 | Imprecise data bus error event |
| ibus_taken | input | 1 | Fetch bus-error exception taken |
| dbus_taken | input | 1 | Data bus-error exception taken |
| exc_inhibit | input | 1 | Imprecise exception inhibit |
| timer_run_dbg | output | 1 | Timer runs in debug mode |
| dseg_to_mem | output | 1 | Debug-segment accesses go to main memory |
| ibus_exc_req | output | 1 | Fetch bus-error exception request |
| dbus_exc_req | output | 1 | Data bus-error exception request |

## Verification
Every register field in the read word and the two control outputs reflects a write or strobe exactly one clock edge after it. The bench drives inputs just after the falling edge and checks one nanosecond later, so what it sees is the result of the previous rising edge. The exception requests have no register in the path from `exc_inhibit`, so they are compared in the same sampling window against the model's pending state and the inhibit value just driven. The reference model updates on each rising edge from the inputs the bench applied. The captured status bits are masked until the model has seen a first entry.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  localparam int DW        = 32;
  localparam int B_DSLOT   = 31;
  localparam int B_DMODE   = 30;
  localparam int B_DSEG    = 28;
  localparam int B_LOWPWR  = 27;
  localparam int B_CLKRUN  = 26;
  localparam int B_TMRRUN  = 25;
  localparam int B_IBUSPND = 24;
  localparam int B_DBUSPND = 21;
  localparam int NUM_PEND  = 2;
  localparam int NUM_CAP   = 3;
  localparam int PEND_POS [NUM_PEND] = '{B_IBUSPND, B_DBUSPND};
  localparam int CAP_POS  [NUM_CAP]  = '{B_CLKRUN, B_LOWPWR, B_DSLOT};
endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dbg_rw_field.sv
module dbg_rw_field #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/dbg_mode_flag.sv
module dbg_mode_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic leave,
  output logic active
);
  logic active_nxt;

  always_comb begin
    active_nxt = active;
    if (enter)      active_nxt = 1'b1;
    else if (leave) active_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else        active <= active_nxt;
  end
endmodule

// File: rtl/dbg_entry_capture.sv
module dbg_entry_capture #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         capture,
  input  logic [W-1:0] status_in,
  output logic [W-1:0] status_q
);
  logic [W-1:0] status_nxt;

  always_comb begin
    status_nxt = status_q;
    if (capture) status_nxt = status_in;
  end

  always_ff @(posedge clk) begin
    status_q <= status_nxt;
  end
endmodule

// File: rtl/dbg_pend_bit.sv
module dbg_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_set,
  input  logic taken,
  input  logic inhibit,
  output logic pend,
  output logic req
);
  logic pend_nxt;
  logic any_set;

  assign any_set = hw_set | sw_set;

  always_comb begin
    pend_nxt = pend;
    if (any_set)    pend_nxt = 1'b1;
    else if (taken) pend_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_nxt;
  end

  assign req = pend & ~inhibit;
endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
  import dbg_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_wr_en,
  input  logic [DW-1:0] sw_wdata,
  output logic [DW-1:0] sw_rdata,
  input  logic          dx_entry,
  input  logic          dx_exit,
  input  logic          dx_in_dslot,
  input  logic          dx_lowpwr,
  input  logic          dx_clk_run,
  input  logic          ibus_err_evt,
  input  logic          dbus_err_evt,
  input  logic          ibus_taken,
  input  logic          dbus_taken,
  input  logic          exc_inhibit,
  output logic          timer_run_dbg,
  output logic          dseg_to_mem,
  output logic          ibus_exc_req,
  output logic          dbus_exc_req
);
  logic                rst_sync_n;
  logic                mode_q;
  logic [NUM_CAP-1:0]  cap_in;
  logic [NUM_CAP-1:0]  cap_q;
  logic [NUM_PEND-1:0] pend_evt;
  logic [NUM_PEND-1:0] pend_ack;
  logic [NUM_PEND-1:0] pend_q;
  logic [NUM_PEND-1:0] pend_req;

  dbg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dbg_mode_flag u_mode (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .enter  (dx_entry),
    .leave  (dx_exit),
    .active (mode_q)
  );

  assign cap_in = {dx_in_dslot, dx_lowpwr, dx_clk_run};

  dbg_entry_capture #(.W(NUM_CAP)) u_cap (
    .clk       (clk),
    .capture   (dx_entry),
    .status_in (cap_in),
    .status_q  (cap_q)
  );

  dbg_rw_field #(.W(1), .RST_VAL(1'b0)) u_dseg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (sw_wr_en),
    .wr_val (sw_wdata[B_DSEG]),
    .q      (dseg_to_mem)
  );

  dbg_rw_field #(.W(1), .RST_VAL(1'b1)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (sw_wr_en),
    .wr_val (sw_wdata[B_TMRRUN]),
    .q      (timer_run_dbg)
  );

  assign pend_evt = {dbus_err_evt, ibus_err_evt};
  assign pend_ack = {dbus_taken, ibus_taken};

  for (genvar g = 0; g < NUM_PEND; g++) begin : g_pend
    dbg_pend_bit u_pend (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .hw_set  (pend_evt[g]),
      .sw_set  (sw_wr_en & sw_wdata[PEND_POS[g]]),
      .taken   (pend_ack[g]),
      .inhibit (exc_inhibit),
      .pend    (pend_q[g]),
      .req     (pend_req[g])
    );
  end

  assign ibus_exc_req = pend_req[0];
  assign dbus_exc_req = pend_req[1];

  always_comb begin
    sw_rdata          = '0;
    sw_rdata[B_DMODE] = mode_q;
    sw_rdata[B_DSEG]  = dseg_to_mem;
    sw_rdata[B_TMRRUN] = timer_run_dbg;
    for (int i = 0; i < NUM_CAP; i++)  sw_rdata[CAP_POS[i]]  = cap_q[i];
    for (int i = 0; i < NUM_PEND; i++) sw_rdata[PEND_POS[i]] = pend_q[i];
  end
endmodule

// File: rtl/dbg_ctl_chk.sv
module dbg_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_wr_en,
  input logic [31:0] sw_wdata,
  input logic [31:0] sw_rdata,
  input logic        dx_entry,
  input logic        dx_exit,
  input logic        dx_in_dslot,
  input logic        ibus_err_evt,
  input logic        dbus_err_evt,
  input logic        ibus_taken,
  input logic        exc_inhibit,
  input logic        timer_run_dbg,
  input logic        dseg_to_mem,
  input logic        ibus_exc_req,
  input logic        dbus_exc_req
);
  a_r2_entry_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    dx_entry |=> sw_rdata[30]);
  a_r2_exit_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_exit && !dx_entry) |=> !sw_rdata[30]);
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata[29] == 1'b0) && (sw_rdata[23:22] == 2'b00) && (sw_rdata[20:0] == '0));
  a_r4_dseg_write: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> (dseg_to_mem == $past(sw_wdata[28])));
  a_r5_timer_write: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> (timer_run_dbg == $past(sw_wdata[25])));
  a_r6_dslot_capture: assert property (@(posedge clk) disable iff (!rst_n)
    dx_entry |=> (sw_rdata[31] == $past(dx_in_dslot)));
  a_r6_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dx_entry && !$isunknown(sw_rdata[31])) |=> $stable(sw_rdata[31]));
  a_r7_ibus_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ibus_err_evt |=> sw_rdata[24]);
  a_r7_dbus_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_err_evt |=> sw_rdata[21]);
  a_r7_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata[24] && sw_wr_en && !sw_wdata[24] && !ibus_taken) |=> sw_rdata[24]);
  a_r8_taken_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_taken && !ibus_err_evt && !(sw_wr_en && sw_wdata[24])) |=> !sw_rdata[24]);
  a_r9_ibus_req: assert property (@(posedge clk) disable iff (!rst_n)
    ibus_exc_req == (sw_rdata[24] && !exc_inhibit));
  a_r9_dbus_req: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_exc_req == (sw_rdata[21] && !exc_inhibit));
endmodule

bind dbg_ctl_reg dbg_ctl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .sw_wr_en      (sw_wr_en),
  .sw_wdata      (sw_wdata),
  .sw_rdata      (sw_rdata),
  .dx_entry      (dx_entry),
  .dx_exit       (dx_exit),
  .dx_in_dslot   (dx_in_dslot),
  .ibus_err_evt  (ibus_err_evt),
  .dbus_err_evt  (dbus_err_evt),
  .ibus_taken    (ibus_taken),
  .exc_inhibit   (exc_inhibit),
  .timer_run_dbg (timer_run_dbg),
  .dseg_to_mem   (dseg_to_mem),
  .ibus_exc_req  (ibus_exc_req),
  .dbus_exc_req  (dbus_exc_req)
);

// File: tb/dbg_ctl_reg_bench.sv
`timescale 1ns/1ps
module dbg_ctl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr_en;
  logic [31:0] sw_wdata;
  logic [31:0] sw_rdata;
  logic        dx_entry, dx_exit, dx_in_dslot, dx_lowpwr, dx_clk_run;
  logic        ibus_err_evt, dbus_err_evt, ibus_taken, dbus_taken, exc_inhibit;
  logic        timer_run_dbg, dseg_to_mem, ibus_exc_req, dbus_exc_req;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // reference state
  bit m_mode, m_dseg, m_tmr, m_ipend, m_dpend, m_cap_ok;
  bit [2:0] m_cap; // {dslot, lowpwr, clkrun}

  always #2.5 clk = ~clk;

  dbg_ctl_reg u_dbg_ctl_reg (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .dx_entry(dx_entry), .dx_exit(dx_exit),
    .dx_in_dslot(dx_in_dslot), .dx_lowpwr(dx_lowpwr), .dx_clk_run(dx_clk_run),
    .ibus_err_evt(ibus_err_evt), .dbus_err_evt(dbus_err_evt),
    .ibus_taken(ibus_taken), .dbus_taken(dbus_taken), .exc_inhibit(exc_inhibit),
    .timer_run_dbg(timer_run_dbg), .dseg_to_mem(dseg_to_mem),
    .ibus_exc_req(ibus_exc_req), .dbus_exc_req(dbus_exc_req)
  );

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[30] = m_mode; w[28] = m_dseg; w[25] = m_tmr;
    w[24] = m_ipend; w[21] = m_dpend;
    w[31] = m_cap[2]; w[27] = m_cap[1]; w[26] = m_cap[0];
    return w;
  endfunction

  function automatic logic [31:0] cmp_mask();
    return m_cap_ok ? 32'hFFFF_FFFF : ~32'h8C00_0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 R3 R6 R7 R8 word"}, sw_rdata & cmp_mask(), exp_word() & cmp_mask());
    chk({tag, " R4 dseg"}, 32'(dseg_to_mem), 32'(m_dseg));
    chk({tag, " R5 timer"}, 32'(timer_run_dbg), 32'(m_tmr));
    chk({tag, " R9 ireq"}, 32'(ibus_exc_req), 32'(m_ipend & ~exc_inhibit));
    chk({tag, " R9 dreq"}, 32'(dbus_exc_req), 32'(m_dpend & ~exc_inhibit));
  endtask

  task automatic clear_inputs();
    sw_wr_en = 0; sw_wdata = '0; dx_entry = 0; dx_exit = 0; dx_in_dslot = 0;
    dx_lowpwr = 0; dx_clk_run = 0; ibus_err_evt = 0; dbus_err_evt = 0;
    ibus_taken = 0; dbus_taken = 0; exc_inhibit = 0;
  endtask

  // inputs already driven after a falling edge: check, then advance one edge
  task automatic step(string tag);
    #1;
    check_all(tag);
    @(posedge clk);
    if (dx_entry) begin m_mode = 1; m_cap = {dx_in_dslot, dx_lowpwr, dx_clk_run}; m_cap_ok = 1; end
    else if (dx_exit) m_mode = 0;
    if (sw_wr_en) begin m_dseg = sw_wdata[28]; m_tmr = sw_wdata[25]; end
    if (ibus_err_evt || (sw_wr_en && sw_wdata[24])) m_ipend = 1;
    else if (ibus_taken) m_ipend = 0;
    if (dbus_err_evt || (sw_wr_en && sw_wdata[21])) m_dpend = 1;
    else if (dbus_taken) m_dpend = 0;
    @(negedge clk);
    clear_inputs();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_inputs();
    rst_n = 0;
    m_mode = 0; m_dseg = 0; m_tmr = 1; m_ipend = 0; m_dpend = 0; m_cap = 0; m_cap_ok = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    #1;
    chk("R1 reset word", sw_rdata & 32'h5320_0000, 32'h0200_0000);
    chk("R1 outputs", {28'd0, timer_run_dbg, dseg_to_mem, ibus_exc_req, dbus_exc_req}, 32'h8);
    @(negedge clk);

    // R3 R6: write all ones, read-only and reserved bits unaffected
    sw_wr_en = 1; sw_wdata = 32'hFFFF_FFFF; step("dir allones");
    sw_wr_en = 1; sw_wdata = 32'h0000_0000; step("dir zero write R7");
    // R6 capture then hold
    dx_entry = 1; dx_in_dslot = 1; dx_lowpwr = 0; dx_clk_run = 1; step("dir entry");
    dx_in_dslot = 0; dx_lowpwr = 1; dx_clk_run = 0; step("dir hold R6");
    // R2 entry beats exit
    dx_entry = 1; dx_exit = 1; step("dir both R2");
    dx_exit = 1; step("dir exit R2");
    // R8 set wins over taken
    ibus_taken = 1; ibus_err_evt = 1; dbus_taken = 1; sw_wr_en = 1; sw_wdata = 32'h0020_0000;
    step("dir setwins R8");
    exc_inhibit = 1; step("dir inhibit R9");
    ibus_taken = 1; dbus_taken = 1; step("dir taken R8");
    step("dir idle");

    for (int n = 0; n < 3000; n++) begin
      sw_wr_en     = ($urandom % 4) == 0;
      sw_wdata     = $urandom;
      dx_entry     = ($urandom % 8) == 0;
      dx_exit      = ($urandom % 8) == 0;
      dx_in_dslot  = $urandom;
      dx_lowpwr    = $urandom;
      dx_clk_run   = $urandom;
      ibus_err_evt = ($urandom % 10) == 0;
      dbus_err_evt = ($urandom % 10) == 0;
      ibus_taken   = ($urandom % 5) == 0;
      dbus_taken   = ($urandom % 5) == 0;
      exc_inhibit  = $urandom;
      step("rnd");
    end
    #1 check_all("final");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule